// File: doc/BRIEF.md
# Block Transfer Engine with Bus Arbitration Handshake

This block copies a run of data words between a peripheral and a synchronous memory port without the processor doing the moves. Software sets up the job through a small write/read register port: it gives the starting memory word address, the number of words, which way the words flow and how the bus is to be held. It then sets a start bit. The engine requests the system bus and waits for the grant. For each word it waits for the peripheral's service request and answers it with an acknowledge, stepping its address and word count as each word moves.

Two bus-holding policies are offered. In burst policy, the request stays raised from start to finish, so the processor cannot get back in until the block is done. In cycle-steal policy, the request is dropped after every word and raised again for the next one, so bus cycles alternate with the processor. When the last word has moved, the engine gives up the bus. In that same cycle it sends a one-cycle completion pulse, and it leaves a sticky done flag that software can read.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After reset, bus_req, per_ack, mem_en and xfer_done are low, and selectors 0, 1 and 2 of the register port all read zero.
- R2: Register selector 0 holds the memory word address and selector 1 holds the word count. On writes to selector 2, bit 0 is start, bit 1 is direction (0 = peripheral to memory, 1 = memory to peripheral) and bit 2 is policy (0 = burst, 1 = cycle-steal). Reads of selector 2 return direction in bit 1, policy in bit 2, busy in bit 3 and done in bit 4, with all other bits zero.
- R3: No memory access and no peripheral acknowledge happens unless bus_req is high. A word begins only in a cycle after the grant and the peripheral request are both seen high; while either is low, nothing moves.
- R4: For peripheral to memory, each word takes one cycle in which per_ack, mem_en and mem_we are high together, and per_rdata is written at the current address.
- R5: For memory to peripheral, a memory read of the current address is issued, and in the next cycle per_ack is high with per_wdata equal to the word that was read.
- R6: On every clock edge where per_ack is high, the count goes down by one and the address goes up by one.
- R7: In burst policy, bus_req rises once at start and stays high until the transfer completes, including while the peripheral stalls.
- R8: In cycle-steal policy, bus_req goes low for at least one cycle after each word. If words remain, it rises again, so there is one request per word.
- R9: In the cycle after the last word, xfer_done is high for exactly one cycle and bus_req is already low. The done bit then reads 1 until the next accepted start clears it.
- R10: A start with a count of zero raises xfer_done in the cycle after the start write, sets done, and never raises bus_req.
- R11: While busy, writes to any selector, including another start, are ignored.
- R12: While the peripheral request is low during a transfer, no acknowledge is given and the count holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wsel | input | 2 | Register selector for writes |
| reg_wdata | input | REG_W | Register write data |
| reg_rsel | input | 2 | Register selector for reads |
| reg_rdata | output | REG_W | Register read data (combinational) |
| bus_req | output | 1 | System bus request toward the processor |
| bus_gnt | input | 1 | System bus grant from the processor |
| xfer_done | output | 1 | One-cycle transfer-complete pulse |
| per_req | input | 1 | Peripheral service request |
| per_ack | output | 1 | Peripheral acknowledge, one per word |
| per_rdata | input | DW | Word supplied by the peripheral |
| per_wdata | output | DW | Word delivered to the peripheral |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after the read |

## Verification
The bench holds the peripheral request low after a burst start, to show that the bus stays held with no acknowledge and no count change. An engine that let go of the bus during the stall would show a second request rise. An engine that moved words anyway would corrupt memory. The bench also withholds the grant in cycle-steal policy, where an engine that ignored the grant would write memory early. It counts request rises per block, so that a burst that dropped the bus, or a cycle-steal that kept it, shows a wrong count. It further covers a zero-count start, which must complete at once with no bus request and not wrap into a long transfer, and writes made while busy, which must not disturb the running address, count or direction.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ARB  = 3'd1,
    ST_MOVE = 3'd2,
    ST_HAND = 3'd3,
    ST_GAP  = 3'd4
  } dma_state_e;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  localparam int CTL_START = 0;
  localparam int CTL_DIR   = 1;
  localparam int CTL_MODE  = 2;
  localparam int CTL_BUSY  = 3;
  localparam int CTL_DONE  = 4;
endpackage

// File: rtl/dma_rst_sync.sv
`timescale 1ns/1ps
module dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dma_cfg_regs.sv
`timescale 1ns/1ps
module dma_cfg_regs
  import dma_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int AW    = 16,
  parameter int CW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [REG_W-1:0] rd_data,
  input  logic             busy,
  input  logic             step,
  input  logic             finish,
  output logic             start,
  output logic [AW-1:0]    addr_q,
  output logic [CW-1:0]    count_q,
  output logic             dir_q,
  output logic             mode_q,
  output logic             done_q
);
  localparam logic [AW-1:0] ADDR_INC = AW'(1);
  localparam logic [CW-1:0] CNT_DEC  = CW'(1);

  logic            idle_wr;
  logic            addr_en, cnt_en, ctl_en, done_en;
  logic [AW-1:0]   addr_d;
  logic [CW-1:0]   cnt_d;
  logic            dir_d, mode_d, done_d;

  // next-state
  always_comb begin
    idle_wr = wr_en && !busy;
    start   = idle_wr && (wr_sel == SEL_CTRL) && wr_data[CTL_START];

    addr_en = step || (idle_wr && (wr_sel == SEL_ADDR));
    addr_d  = step ? (addr_q + ADDR_INC) : wr_data[AW-1:0];

    cnt_en  = step || (idle_wr && (wr_sel == SEL_COUNT));
    cnt_d   = step ? (count_q - CNT_DEC) : wr_data[CW-1:0];

    ctl_en  = idle_wr && (wr_sel == SEL_CTRL);
    dir_d   = wr_data[CTL_DIR];
    mode_d  = wr_data[CTL_MODE];

    done_en = finish || start;
    done_d  = finish;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      count_q <= '0;
      dir_q   <= 1'b0;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (addr_en) addr_q  <= addr_d;
      if (cnt_en)  count_q <= cnt_d;
      if (ctl_en) begin
        dir_q  <= dir_d;
        mode_q <= mode_d;
      end
      if (done_en) done_q <= done_d;
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_ADDR:  rd_data[AW-1:0] = addr_q;
      SEL_COUNT: rd_data[CW-1:0] = count_q;
      SEL_CTRL: begin
        rd_data[CTL_DIR]  = dir_q;
        rd_data[CTL_MODE] = mode_q;
        rd_data[CTL_BUSY] = busy;
        rd_data[CTL_DONE] = done_q;
      end
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dma_seq.sv
`timescale 1ns/1ps
module dma_seq
  import dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic dir,
  input  logic mode,
  input  logic cnt_zero,
  input  logic cnt_one,
  input  logic bus_gnt,
  input  logic per_req,
  output logic busy,
  output logic step,
  output logic finish,
  output logic bus_req,
  output logic per_ack,
  output logic mem_en,
  output logic mem_we,
  output logic xfer_done
);
  dma_state_e state_q, state_d;
  logic       word_end;
  logic       done_pulse_q;

  // next-state and decoded outputs
  always_comb begin
    state_d  = state_q;
    bus_req  = 1'b0;
    per_ack  = 1'b0;
    mem_en   = 1'b0;
    mem_we   = 1'b0;
    word_end = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start && !cnt_zero) state_d = ST_ARB;
      end
      ST_ARB: begin
        bus_req = 1'b1;
        if (bus_gnt && per_req) state_d = ST_MOVE;
      end
      ST_MOVE: begin
        bus_req = 1'b1;
        mem_en  = 1'b1;
        if (!dir) begin
          mem_we   = 1'b1;
          per_ack  = 1'b1;
          word_end = 1'b1;
        end else begin
          state_d = ST_HAND;
        end
      end
      ST_HAND: begin
        bus_req  = 1'b1;
        per_ack  = 1'b1;
        word_end = 1'b1;
      end
      ST_GAP: begin
        state_d = ST_ARB;
      end
      default: state_d = ST_IDLE;
    endcase
    if (word_end) begin
      if (cnt_one)   state_d = ST_IDLE;
      else if (mode) state_d = ST_GAP;
      else           state_d = ST_ARB;
    end
    step   = word_end;
    finish = ((state_q == ST_IDLE) && start && cnt_zero) || (word_end && cnt_one);
    busy   = (state_q != ST_IDLE);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      done_pulse_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      done_pulse_q <= finish;
    end
  end

  assign xfer_done = done_pulse_q;
endmodule

// File: rtl/dma_xfer_ctrl.sv
`timescale 1ns/1ps
module dma_xfer_ctrl #(
  parameter int REG_W = 16,
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_wsel,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic [1:0]       reg_rsel,
  output logic [REG_W-1:0] reg_rdata,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic             xfer_done,
  input  logic             per_req,
  output logic             per_ack,
  input  logic [DW-1:0]    per_rdata,
  output logic [DW-1:0]    per_wdata,
  output logic             mem_en,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic          rst_sync_n;
  logic          start, busy, step, finish;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] count_q;
  logic          dir_q, mode_q, done_q;
  logic          cnt_zero, cnt_one;

  dma_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dma_cfg_regs #(.REG_W(REG_W), .AW(AW), .CW(CW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_wr),
    .wr_sel  (reg_wsel),
    .wr_data (reg_wdata),
    .rd_sel  (reg_rsel),
    .rd_data (reg_rdata),
    .busy    (busy),
    .step    (step),
    .finish  (finish),
    .start   (start),
    .addr_q  (addr_q),
    .count_q (count_q),
    .dir_q   (dir_q),
    .mode_q  (mode_q),
    .done_q  (done_q)
  );

  assign cnt_zero = (count_q == '0);
  assign cnt_one  = (count_q == CNT_ONE);

  dma_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .dir       (dir_q),
    .mode      (mode_q),
    .cnt_zero  (cnt_zero),
    .cnt_one   (cnt_one),
    .bus_gnt   (bus_gnt),
    .per_req   (per_req),
    .busy      (busy),
    .step      (step),
    .finish    (finish),
    .bus_req   (bus_req),
    .per_ack   (per_ack),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .xfer_done (xfer_done)
  );

  assign mem_addr  = addr_q;
  assign mem_wdata = per_rdata;
  assign per_wdata = mem_rdata;
endmodule

// File: rtl/dma_xfer_ctrl_chk.sv
`timescale 1ns/1ps
module dma_xfer_ctrl_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          per_ack,
  input logic          mem_en,
  input logic          mem_we,
  input logic          xfer_done,
  input logic          busy,
  input logic          mode_q,
  input logic [AW-1:0] addr_q,
  input logic [CW-1:0] count_q
);
  localparam logic [AW-1:0] A_ONE = AW'(1);
  localparam logic [CW-1:0] C_ONE = CW'(1);

  AST_XFER_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (per_ack || mem_en) |-> bus_req); // R3
  AST_WRITE_HAS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> per_ack); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |=> (count_q == ($past(count_q) - C_ONE))); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack |=> (addr_q == ($past(addr_q) + A_ONE))); // R6
  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && $fell(bus_req)) |-> xfer_done); // R7
  AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && per_ack) |=> !bus_req); // R8
  AST_DONE_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!bus_req && !busy)); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done); // R9
endmodule

bind dma_xfer_ctrl dma_xfer_ctrl_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_req   (bus_req),
  .per_ack   (per_ack),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .xfer_done (xfer_done),
  .busy      (busy),
  .mode_q    (mode_q),
  .addr_q    (addr_q),
  .count_q   (count_q)
);

// File: tb/dma_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module dma_xfer_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_wsel = '0;
  logic [15:0] reg_wdata = '0;
  logic [1:0]  reg_rsel = '0;
  logic [15:0] reg_rdata;
  logic        bus_req, bus_gnt, xfer_done;
  logic        per_req, per_ack;
  logic [15:0] per_rdata, per_wdata;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  logic        gnt_allow = 1'b1;
  logic        per_allow = 1'b1;
  logic [15:0] per_idx;
  logic [15:0] mem [0:255];
  logic [15:0] cap [0:15];
  int          total = 0;
  int          bad = 0;

  always #2.5 clk = ~clk;

  dma_xfer_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wsel(reg_wsel),
    .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .xfer_done(xfer_done),
    .per_req(per_req), .per_ack(per_ack), .per_rdata(per_rdata),
    .per_wdata(per_wdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // processor grant: follows request one cycle later when allowed
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_gnt <= 1'b0;
    else        bus_gnt <= bus_req & gnt_allow;
  end

  // synchronous memory, preset to 0x5000 + index
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 16'h5000 + 16'(i);
      mem_rdata <= '0;
    end else if (mem_en) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
    end
  end

  // peripheral: supplies 0xA000 + word number, captures delivered words
  assign per_req   = per_allow;
  assign per_rdata = 16'hA000 + per_idx;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) per_idx <= '0;
    else if (per_ack) begin
      cap[per_idx[3:0]] <= per_wdata;
      per_idx <= per_idx + 16'd1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [15:0] data);
    reg_wr = 1'b1; reg_wsel = sel; reg_wdata = data;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] sel, output logic [15:0] v);
    reg_rsel = sel;
    #0.5;
    v = reg_rdata;
  endtask

  // control word: bit0 start, bit1 direction, bit2 policy
  task automatic kick(input logic [15:0] addr, input logic [15:0] cnt, input logic d, input logic m);
    reg_write(2'd0, addr);
    reg_write(2'd1, cnt);
    reg_write(2'd2, {13'd0, m, d, 1'b1});
  endtask

  task automatic wait_done(input logic req0, output int rises, output int acks,
                           output logic seen, output logic ack_before,
                           output logic req_at_done, output logic one_cycle);
    logic prev_req, prev_ack;
    rises = 0; acks = 0; seen = 1'b0; prev_req = req0; prev_ack = 1'b0;
    ack_before = 1'b0; req_at_done = 1'b1; one_cycle = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      if (bus_req && !prev_req) rises++;
      if (per_ack) acks++;
      if (xfer_done) begin
        seen = 1'b1; ack_before = prev_ack; req_at_done = bus_req;
      end else begin
        prev_req = bus_req; prev_ack = per_ack;
        @(negedge clk);
      end
    end
    @(negedge clk);
    one_cycle = !xfer_done;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 bus_req", bus_req, 0);
    chk("R1 per_ack", per_ack, 0);
    chk("R1 mem_en", mem_en, 0);
    chk("R1 xfer_done", xfer_done, 0);
    reg_read(2'd0, v); chk("R1 addr reg", v, 0);
    reg_read(2'd1, v); chk("R1 count reg", v, 0);
    reg_read(2'd2, v); chk("R1 ctrl reg", v, 0);
  endtask

  task automatic t_burst_p2m();
    int rises, acks; logic seen, ab, rd, oc; logic [15:0] v, base;
    base = per_idx;
    kick(16'h0010, 16'd4, 1'b0, 1'b0);
    wait_done(1'b0, rises, acks, seen, ab, rd, oc);
    chk("R9 done seen burst", seen, 1);
    chk("R7 one request per burst", rises, 1);
    chk("R4 word count", acks, 4);
    chk("R9 pulse follows last word", ab, 1);
    chk("R9 bus_req low with pulse", rd, 0);
    chk("R9 pulse one cycle", oc, 1);
    for (int i = 0; i < 4; i++) chk("R4 memory word", mem[16 + i], 16'hA000 + base + 16'(i));
    chk("R4 neighbour untouched", mem[20], 16'h5014);
    reg_read(2'd0, v); chk("R6 final addr", v, 16'h0014);
    reg_read(2'd1, v); chk("R6 final count", v, 0);
    reg_read(2'd2, v); chk("R2 R9 status burst p2m", v, 16'h0010);
  endtask

  task automatic t_steal_m2p();
    int rises, acks; logic seen, ab, rd, oc; logic [15:0] v, base;
    base = per_idx;
    kick(16'h0040, 16'd3, 1'b1, 1'b1);
    wait_done(1'b0, rises, acks, seen, ab, rd, oc);
    chk("R9 done seen steal", seen, 1);
    chk("R8 one request per word", rises, 3);
    chk("R5 word count", acks, 3);
    chk("R9 bus_req low with pulse", rd, 0);
    for (int i = 0; i < 3; i++)
      chk("R5 delivered word", cap[(base[3:0] + 4'(i))], 16'h5040 + 16'(i));
    reg_read(2'd0, v); chk("R6 final addr m2p", v, 16'h0043);
    reg_read(2'd2, v); chk("R2 status steal m2p", v, 16'h0016);
  endtask

  task automatic t_stall_lock();
    int rises, acks, stall_acks; logic seen, ab, rd, oc; logic [15:0] v, base;
    per_allow = 1'b0;
    base = per_idx;
    kick(16'h0020, 16'd3, 1'b0, 1'b0);
    stall_acks = 0;
    for (int i = 0; i < 8; i++) begin
      if (per_ack || mem_en) stall_acks++;
      @(negedge clk);
    end
    chk("R12 no ack while stalled", stall_acks, 0);
    chk("R7 bus held during stall", bus_req, 1);
    reg_read(2'd1, v); chk("R12 count holds", v, 3);
    reg_write(2'd0, 16'h0099);
    reg_write(2'd1, 16'd7);
    reg_write(2'd2, 16'h0007);
    reg_read(2'd0, v); chk("R11 addr locked", v, 16'h0020);
    reg_read(2'd1, v); chk("R11 count locked", v, 3);
    reg_read(2'd2, v); chk("R11 R9 ctrl locked, done cleared", v, 16'h0008);
    per_allow = 1'b1;
    wait_done(1'b1, rises, acks, seen, ab, rd, oc);
    chk("R9 done seen after stall", seen, 1);
    chk("R7 no new request", rises, 0);
    chk("R12 words after release", acks, 3);
    for (int i = 0; i < 3; i++) chk("R4 stalled memory word", mem[32 + i], 16'hA000 + base + 16'(i));
  endtask

  task automatic t_grant_wait();
    int rises, acks, early; logic seen, ab, rd, oc;
    gnt_allow = 1'b0;
    kick(16'h0030, 16'd2, 1'b0, 1'b1);
    early = 0;
    for (int i = 0; i < 8; i++) begin
      if (per_ack || mem_en) early++;
      @(negedge clk);
    end
    chk("R3 nothing moves without grant", early, 0);
    chk("R3 request raised", bus_req, 1);
    chk("R3 memory untouched", mem[48], 16'h5030);
    gnt_allow = 1'b1;
    wait_done(1'b1, rises, acks, seen, ab, rd, oc);
    chk("R9 done seen grant test", seen, 1);
    chk("R8 re-request for second word", rises, 1);
    chk("R3 words after grant", acks, 2);
    chk("R3 word written", mem[49][15:12], 4'hA);
  endtask

  task automatic t_zero_count();
    int reqs; logic [15:0] v;
    reg_write(2'd1, 16'd0);
    reg_write(2'd0, 16'h0050);
    reg_write(2'd2, 16'h0001);
    chk("R10 immediate pulse", xfer_done, 1);
    chk("R10 no request", bus_req, 0);
    reqs = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (bus_req || mem_en) reqs++;
    end
    chk("R10 stays quiet", reqs, 0);
    reg_read(2'd2, v); chk("R10 done set", v, 16'h0010);
    reg_read(2'd0, v); chk("R10 addr unchanged", v, 16'h0050);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_burst_p2m();
    t_steal_m2p();
    t_stall_lock();
    t_grant_wait();
    t_zero_count();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule